// File: doc/BRIEF.md
# Two-Level Descriptor Cookie Translator

This block resolves a compact 20-bit descriptor cookie into the 64-bit virtual address of the descriptor it names. The cookie has two parts. The upper part indexes a primary table held in a local 64-bit-wide memory. That table yields the physical base of a secondary page. The lower part selects one 8-byte slot inside that page. The block fetches the slot from the page with a single read on a request/response memory port. The value it gets back is the descriptor address, and it returns that value on a valid/ready result port.

Primary entries come in two formats, chosen by a mode input that is sampled when a request is accepted.
- In the packed format, each 64-bit table word holds two 32-bit page-frame numbers. A frame number becomes a page address after a fixed 12-bit left shift.
- In the wide format, each table word holds a full 64-bit page address.

Software preloads the table through a write port. The block handles one translation at a time.

Top module: `cookie_xlate_top`

## Requirements
- R1: After reset `in_ready` is 1, and `out_valid` and `mem_req_valid` are 0.
- R2: Cookie bits [8:0] are the slot offset. The fetch address on `mem_req_addr` is the page base plus the offset times 8.
- R3: With `mode_unaligned`=0, cookie bits [19:10] pick the table word. Bit 9 picks the upper half [63:32] when 1 and the lower half [31:0] when 0. The page base is that 32-bit half shifted left by 12.
- R4: With `mode_unaligned`=1, cookie bits [19:9] pick the table word, and the whole 64-bit word is the page base.
- R5: Cookie bits [31:20] have no effect on the fetch address or the result.
- R6: `in_ready` falls after an acceptance and stays 0 until the result is consumed. Each successful translation issues exactly one memory request.
- R7: If the selected word index is 512 or more in either mode, the result carries `out_err`=1 and `out_addr`=0, and no memory request is issued.
- R8: `out_addr` equals the memory response data. While `out_valid` is 1 and `out_ready` is 0, the result and the error flag hold steady.
- R9: The memory response may arrive any number of cycles after the request is accepted. An unaccepted request keeps its address steady.
- R10: A table write in the same cycle as an acceptance that reads the same word leaves that lookup with the old contents. The following lookup sees the new contents.
- R11: With `tw_en`=1, the 64-bit `tw_data` is stored at table word `tw_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_unaligned | input | 1 | Entry format: 0 packed 32-bit frame numbers, 1 full 64-bit addresses |
| in_valid | input | 1 | Cookie request valid |
| in_ready | output | 1 | Translator can accept a cookie |
| in_cookie | input | 32 | Cookie; bits [19:0] used |
| tw_en | input | 1 | Table write enable |
| tw_addr | input | 9 | Table word address |
| tw_data | input | 64 | Table word data |
| mem_req_valid | output | 1 | Slot read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Slot address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Slot contents (descriptor address) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 64 | Descriptor address, 0 on error |
| out_err | output | 1 | Index out of table range |

## Verification
A table write and a lookup read can land on the same table word in the same cycle. The bench provokes this by raising `tw_en` on the very cycle a cookie is accepted, aimed at the word that cookie selects. It judges the result in two steps. First, the slot address issued to memory must be built from the pre-write word. Second, a repeat of the same cookie must be built from the newly written word. Delays on the request, the response and the result are varied across the vectors, so the hold-steady behaviour is exercised alongside this.

// File: rtl/cx_pkg.sv
package cx_pkg;
  typedef enum logic [2:0] {
    CX_IDLE = 3'd0,
    CX_TBL  = 3'd1,
    CX_REQ  = 3'd2,
    CX_RSP  = 3'd3,
    CX_DONE = 3'd4
  } cx_state_e;
endpackage

// File: rtl/cx_table.sv
module cx_table #(
  parameter int WORDS = 512,
  parameter int DW    = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [WORDS];

  // Read returns the contents before any same-cycle write.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cx_index.sv
module cx_index #(
  parameter int COOKIE_W = 20,
  parameter int OFS_W    = 9,
  parameter int WORDS    = 512,
  localparam int IDX_W   = COOKIE_W - OFS_W,
  localparam int AW      = $clog2(WORDS)
) (
  input  logic [IDX_W-1:0] idx_field,
  input  logic             unaligned,
  output logic [AW-1:0]    word,
  output logic             oob
);
  logic [IDX_W-1:0] full;

  always_comb begin
    if (unaligned) full = idx_field;
    else           full = {1'b0, idx_field[IDX_W-1:1]};
    oob  = (full >= IDX_W'(WORDS));
    word = full[AW-1:0];
  end
endmodule

// File: rtl/cx_fetch.sv
module cx_fetch #(
  parameter int OFS_W      = 9,
  parameter int ADDR_W     = 64,
  parameter int PFN_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SLOT_SHIFT = 3
) (
  input  logic [2*PFN_W-1:0] entry,
  input  logic               half_hi,
  input  logic               unaligned,
  input  logic [OFS_W-1:0]   ofs,
  output logic [ADDR_W-1:0]  fetch
);
  logic [PFN_W-1:0]  pfn;
  logic [ADDR_W-1:0] base;

  always_comb begin
    pfn = half_hi ? entry[2*PFN_W-1:PFN_W] : entry[PFN_W-1:0];
    if (unaligned) base = ADDR_W'(entry);
    else           base = ADDR_W'(pfn) << PAGE_SHIFT;
    fetch = base + (ADDR_W'(ofs) << SLOT_SHIFT);
  end
endmodule

// File: rtl/cx_ctrl.sv
module cx_ctrl
  import cx_pkg::*;
#(
  parameter int OFS_W  = 9,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OFS_W:0]    in_lo,
  input  logic              in_mode,
  input  logic              in_oob,
  output logic              tbl_rd,
  output logic [OFS_W-1:0]  ck_ofs,
  output logic              ck_half,
  output logic              ck_mode,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_err
);
  cx_state_e         state_q, state_d;
  logic [OFS_W:0]    lo_q;
  logic              mode_q, err_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ld_ck, ld_addr;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    ld_ck    = 1'b0;
    ld_addr  = 1'b0;
    unique case (state_q)
      CX_IDLE: if (in_valid) begin
        ld_ck   = 1'b1;
        state_d = CX_TBL;
      end
      CX_TBL: begin
        ld_addr = 1'b1;
        if (err_q) begin
          addr_d  = '0;
          state_d = CX_DONE;
        end else begin
          addr_d  = fetch_addr;
          state_d = CX_REQ;
        end
      end
      CX_REQ: if (mem_req_ready) state_d = CX_RSP;
      CX_RSP: if (mem_rsp_valid) begin
        ld_addr = 1'b1;
        addr_d  = mem_rsp_data;
        state_d = CX_DONE;
      end
      CX_DONE: if (out_ready) state_d = CX_IDLE;
      default: state_d = CX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CX_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      mode_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (ld_ck) begin
      lo_q   <= in_lo;
      mode_q <= in_mode;
      err_q  <= in_oob;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (ld_addr) addr_q <= addr_d;
  end

  assign in_ready      = (state_q == CX_IDLE);
  assign tbl_rd        = in_valid && in_ready;
  assign ck_ofs        = lo_q[OFS_W-1:0];
  assign ck_half       = lo_q[OFS_W];
  assign ck_mode       = mode_q;
  assign mem_req_valid = (state_q == CX_REQ);
  assign mem_req_addr  = addr_q;
  assign out_valid     = (state_q == CX_DONE);
  assign out_addr      = addr_q;
  assign out_err       = err_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid && !mem_req_valid));
  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_ready_after_consume_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);
  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_addr == '0));
  assert_no_req_on_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !out_err);
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_err)));
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

// File: rtl/cookie_xlate_top.sv
module cookie_xlate_top #(
  parameter int IN_W     = 32,
  parameter int COOKIE_W = 20,
  parameter int OFS_W    = 9,
  parameter int WORDS    = 512,
  parameter int ADDR_W   = 64,
  localparam int IDX_W   = COOKIE_W - OFS_W,
  localparam int AW      = $clog2(WORDS),
  localparam int PFN_W   = 32,
  localparam int DW      = 2 * PFN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_unaligned,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_cookie,
  input  logic              tw_en,
  input  logic [AW-1:0]     tw_addr,
  input  logic [DW-1:0]     tw_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_err
);
  logic              rst_meta, rst_sn;
  logic [AW-1:0]     word;
  logic              oob, tbl_rd, ck_half, ck_mode;
  logic [OFS_W-1:0]  ck_ofs;
  logic [DW-1:0]     entry;
  logic [ADDR_W-1:0] fetch_addr;
  logic              unused_hi;

  assign unused_hi = ^in_cookie[IN_W-1:COOKIE_W];

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  cx_index #(.COOKIE_W(COOKIE_W), .OFS_W(OFS_W), .WORDS(WORDS)) u_index (
    .idx_field (in_cookie[COOKIE_W-1:OFS_W]),
    .unaligned (mode_unaligned),
    .word      (word),
    .oob       (oob)
  );

  cx_table #(.WORDS(WORDS), .DW(DW)) u_table (
    .clk     (clk),
    .wr_en   (tw_en),
    .wr_addr (tw_addr),
    .wr_data (tw_data),
    .rd_en   (tbl_rd),
    .rd_addr (word),
    .rd_data (entry)
  );

  cx_fetch #(.OFS_W(OFS_W), .ADDR_W(ADDR_W), .PFN_W(PFN_W)) u_fetch (
    .entry     (entry),
    .half_hi   (ck_half),
    .unaligned (ck_mode),
    .ofs       (ck_ofs),
    .fetch     (fetch_addr)
  );

  cx_ctrl #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sn),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_lo         (in_cookie[OFS_W:0]),
    .in_mode       (mode_unaligned),
    .in_oob        (oob),
    .tbl_rd        (tbl_rd),
    .ck_ofs        (ck_ofs),
    .ck_half       (ck_half),
    .ck_mode       (ck_mode),
    .fetch_addr    (fetch_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_addr      (out_addr),
    .out_err       (out_err)
  );
endmodule

// File: tb/cookie_xlate_top_tb.sv
`timescale 1ns/1ps
module cookie_xlate_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_unaligned = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_cookie = '0;
  logic        tw_en = 1'b0;
  logic [8:0]  tw_addr = '0;
  logic [63:0] tw_data = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_addr;
  logic        out_err;

  int checks = 0;
  int fails  = 0;
  int req_cnt = 0;
  logic [63:0] model [512];

  always #2 clk = ~clk;

  cookie_xlate_top u_dut (
    .clk(clk), .rst_n(rst_n), .mode_unaligned(mode_unaligned),
    .in_valid(in_valid), .in_ready(in_ready), .in_cookie(in_cookie),
    .tw_en(tw_en), .tw_addr(tw_addr), .tw_data(tw_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_err(out_err)
  );

  always @(posedge clk) if (mem_req_valid && mem_req_ready) req_cnt++;

  localparam int NV = 8;
  localparam logic [10:0] V_IDX  [NV] = '{11'd0, 11'd1, 11'd2, 11'd511, 11'd1023, 11'd100, 11'd300, 11'd7};
  localparam logic [8:0]  V_OFS  [NV] = '{9'd0, 9'd511, 9'd5, 9'd17, 9'd256, 9'd1, 9'd300, 9'd8};
  localparam logic        V_MODE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int          V_LAT  [NV] = '{0, 1, 2, 3, 0, 4, 0, 5};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rsp_of(input logic [63:0] a);
    return {a[31:0], a[63:32]} ^ 64'h5A5A_0F0F_C3C3_1234;
  endfunction

  function automatic logic [63:0] exp_fetch(input logic [10:0] idx, input logic [8:0] ofs, input bit un);
    logic [63:0] w, base;
    if (un) base = model[idx[8:0]];
    else begin
      w = model[idx[9:1]];
      base = {20'd0, (idx[0] ? w[63:32] : w[31:0]), 12'd0};
    end
    return base + {52'd0, ofs, 3'd0};
  endfunction

  task automatic xlate(input logic [10:0] idx, input logic [8:0] ofs, input bit un,
                       input logic [11:0] hi, input int lat, input bit exp_err,
                       input bit do_wr, input logic [63:0] wr_val, input string tag);
    logic [63:0] ef;
    int n0, waits;
    bit saw_req;
    ef = exp_err ? 64'd0 : exp_fetch(idx, ofs, un);
    n0 = req_cnt;
    saw_req = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_cookie = {hi, idx, ofs}; mode_unaligned = un;
    if (do_wr) begin tw_en = 1'b1; tw_addr = idx[8:0]; tw_data = wr_val; end
    @(negedge clk);
    in_valid = 1'b0; tw_en = 1'b0;
    chk(in_ready == 1'b0, {tag, " R6 busy after accept"}, {63'd0, in_ready}, 64'd0);
    if (!exp_err) begin
      waits = 0;
      while (!mem_req_valid && waits < 20) begin @(negedge clk); waits++; end
      chk(mem_req_addr == ef, {tag, " R2 fetch address"}, mem_req_addr, ef);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == ef, {tag, " R9 request held"}, mem_req_addr, ef);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      for (int i = 0; i < lat; i++) @(negedge clk);
      mem_rsp_valid = 1'b1; mem_rsp_data = rsp_of(mem_req_addr);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
    end
    waits = 0;
    while (!out_valid && waits < 40) begin
      if (mem_req_valid) saw_req = 1'b1;
      @(negedge clk); waits++;
    end
    if (exp_err) begin
      chk(!saw_req && req_cnt == n0, {tag, " R7 no request"}, 64'(req_cnt - n0), 64'd0);
      chk(out_err == 1'b1 && out_addr == 64'd0, {tag, " R7 error result"}, out_addr, 64'd0);
    end else begin
      chk(req_cnt - n0 == 1, {tag, " R6 one request"}, 64'(req_cnt - n0), 64'd1);
      chk(out_valid && !out_err && out_addr == rsp_of(ef), {tag, " R8 result"}, out_addr, rsp_of(ef));
    end
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(out_valid && out_addr == (exp_err ? 64'd0 : rsp_of(ef)), {tag, " R8 result held"}, out_addr,
          exp_err ? 64'd0 : rsp_of(ef));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, {tag, " R6 ready after consume"}, {63'd0, in_ready}, 64'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int w = 0; w < 512; w++)
      model[w] = {32'h0001_0000 + 32'(w * 7), 32'h0002_0000 + 32'(w * 11)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", {63'd0, in_ready}, 64'd1);
    chk(out_valid == 1'b0, "R1 out_valid", {63'd0, out_valid}, 64'd0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    // R11 preload through the write port
    for (int w = 0; w < 512; w++) begin
      tw_en = 1'b1; tw_addr = 9'(w); tw_data = model[w];
      @(negedge clk);
    end
    tw_en = 1'b0;
    // Vector walk: R3 packed, R4 wide formats
    for (int v = 0; v < NV; v++)
      xlate(V_IDX[v], V_OFS[v], V_MODE[v], 12'd0, V_LAT[v], 1'b0, 1'b0, 64'd0,
            V_MODE[v] ? "R4 vec" : "R3 vec");
    // R5 high cookie bits ignored
    xlate(11'd77, 9'd9, 1'b0, 12'hFFF, 1, 1'b0, 1'b0, 64'd0, "R5 aligned");
    xlate(11'd77, 9'd9, 1'b1, 12'hA5C, 0, 1'b0, 1'b0, 64'd0, "R5 unaligned");
    // R7 out of range
    xlate(11'd512, 9'd3, 1'b1, 12'd0, 2, 1'b1, 1'b0, 64'd0, "R7 unaligned 512");
    xlate(11'd1024, 9'd3, 1'b0, 12'd0, 0, 1'b1, 1'b0, 64'd0, "R7 aligned 1024");
    xlate(11'd2047, 9'd511, 1'b1, 12'd0, 1, 1'b1, 1'b0, 64'd0, "R7 unaligned top");
    // R10 same-cycle write and lookup, then R11 new contents visible
    xlate(11'd40, 9'd6, 1'b1, 12'd0, 1, 1'b0, 1'b1, 64'h0000_0123_4567_8000, "R10 old contents");
    model[40] = 64'h0000_0123_4567_8000;
    xlate(11'd40, 9'd6, 1'b1, 12'd0, 0, 1'b0, 1'b0, 64'd0, "R11 new contents");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule